// File: doc/BRIEF.md
# Two-Channel Quadrature Pulse Counter

The block counts pulses arriving on two input channels into one shared 16-bit signed counter. Each channel pairs a pulse input with a control input. Any rising or falling transition on a pulse input becomes a request to step the counter up, step it down or leave it alone. The level on that channel's control input then either passes the request through, reverses it or suppresses it. When one channel watches the A phase and the other the B phase of an encoder, with the control inputs cross-wired, the unit decodes quadrature motion and gives a position count.

The count is checked against a high limit, a low limit, two thresholds and zero. Each match raises a watch event that has its own enable. Enabled events set sticky flags and one shared, latched interrupt status bit. Software clears that bit by writing a one to it. The direction of the most recent zero crossing is recorded. Every input passes through a two-flop synchronizer and an optional glitch filter. The filter rejects any level that does not hold for a programmable number of clock cycles. Software configures the unit and reads it through a small register port: a write strobe, an address and 32-bit data, with combinational read data.

Top module: `pcnt_unit`

## Requirements
- R1: After reset the count, the status word (address 7), the interrupt status and `irq_o` are all 0. The limit register (address 2) reads 32'h8000_7FFF: high limit 32767 in bits [15:0], low limit -32768 in bits [31:16].
- R2: Each channel has its own configuration word: channel 0 at address 0, channel 1 at address 1. Bits [1:0] give the rising-edge action and bits [3:2] the falling-edge action. The action codes are 0 = hold, 1 = add one, 2 = subtract one, 3 = hold.
- R3: In the same word, bits [5:4] act while the control input is high and bits [7:6] act while it is low. The codes are 0 = keep the edge action, 1 = reverse it, 2 or 3 = hold.
- R4: When both channels request a step in the same clock cycle, their steps are added, so the count moves by -2 to +2 in that cycle.
- R5: The count is 16-bit two's complement. It reads at address 6 sign-extended to 32 bits.
- R6: Address 2 holds the high limit in [15:0] and the low limit in [31:16]. An update that would bring the count to at least the high limit, or to at most the low limit, loads zero instead. It also raises the high-limit or low-limit event.
- R7: Address 3 holds threshold 0 in [15:0] and threshold 1 in [31:16]. An update that leaves the count equal to a threshold raises that threshold's event.
- R8: Status bits [1:0] hold the zero-crossing direction of the most recent crossing: 0 = positive to zero or below, 1 = negative to zero or above, 2 = zero to negative, 3 = zero to positive. Crossing zero raises the zero event.
- R9: The event enables sit in control register (address 4) bits [6:2], in the order threshold 1, threshold 0, low limit, high limit, zero. An enabled event sets its sticky flag in status bits [6:2] and sets the interrupt status. Address 5 holds the interrupt enable in bit 0 and reads the status in bit 1. Writing 1 to bit 1 clears the status and the flags, but an event in the same cycle wins. `irq_o` equals status AND enable.
- R10: While the pause bit (control bit 0) is set, the count does not change.
- R11: While the clear bit (control bit 1) is set, the count is held at zero. Writing 1 and then 0 gives a one-shot reset.
- R12: With the filter enabled (control bit 7) and threshold T in control bits [17:8], an input level held for fewer than T cycles is ignored, and one held for T cycles is accepted.
- R13: With the filter disabled, a pulse edge changes the count on the fourth rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 2 | Pulse input, one per channel |
| ctl_in | input | 2 | Control input, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt output |

## Verification
Two collisions are exercised. The first is both channels stepping in the same clock cycle. The bench raises both pulse inputs on the same clock, once with both channels adding and once with one adding and one subtracting. The count is judged against the arithmetic sum of the two steps. The second is an event and an interrupt clear landing in the same cycle. Counting the register stages from pin to counter, the bench times the clear write so that it lands on the edge where the threshold event fires, and expects the interrupt to stay set.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
    localparam int CNT_W  = 16;
    localparam int FLT_W  = 10;
    localparam int NCH    = 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int NEV    = 5;
    localparam int NIN    = 2 * NCH;

    // event bit order inside enables and flags
    localparam int EV_THR1 = 0;
    localparam int EV_THR0 = 1;
    localparam int EV_LOW  = 2;
    localparam int EV_HIGH = 3;
    localparam int EV_ZERO = 4;

    localparam logic [ADDR_W-1:0] A_LIM  = 3'd2;
    localparam logic [ADDR_W-1:0] A_THR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQ  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

    localparam int CTRL_EV_LSB   = 2;
    localparam int CTRL_FEN      = CTRL_EV_LSB + NEV;
    localparam int CTRL_FTHR_LSB = CTRL_FEN + 1;

    typedef enum logic [1:0] {
        E_HOLD = 2'd0,
        E_INC  = 2'd1,
        E_DEC  = 2'd2,
        E_RSV  = 2'd3
    } edge_act_e;

    typedef enum logic [1:0] {
        L_KEEP = 2'd0,
        L_INV  = 2'd1,
        L_HOLD = 2'd2,
        L_RSV  = 2'd3
    } lvl_act_e;

    typedef enum logic [1:0] {
        ZC_POS_ZERO = 2'd0,
        ZC_NEG_ZERO = 2'd1,
        ZC_ZERO_NEG = 2'd2,
        ZC_ZERO_POS = 2'd3
    } zc_mode_e;

    typedef struct packed {
        logic [1:0] lo_act;
        logic [1:0] hi_act;
        logic [1:0] fall_act;
        logic [1:0] rise_act;
    } chan_cfg_t;

    localparam int CH_CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        chan_cfg_t [NCH-1:0] ch;
        logic [CNT_W-1:0]    hi_lim;
        logic [CNT_W-1:0]    lo_lim;
        logic [CNT_W-1:0]    thr0;
        logic [CNT_W-1:0]    thr1;
        logic                pause;
        logic                clr;
        logic [NEV-1:0]      ev_en;
        logic                flt_en;
        logic [FLT_W-1:0]    flt_thr;
        logic                irq_en;
    } unit_cfg_t;
endpackage

// File: rtl/pcnt_cfg.sv
module pcnt_cfg
    import pcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output unit_cfg_t         cfg_o,
    output logic              irq_clr_o
);
    unit_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        irq_clr_o = 1'b0;
        if (cfg_we) begin
            for (int c = 0; c < NCH; c++) begin
                if (cfg_addr == ADDR_W'(c)) cfg_d.ch[c] = cfg_wdata[CH_CFG_W-1:0];
            end
            case (cfg_addr)
                A_LIM: begin
                    cfg_d.hi_lim = cfg_wdata[CNT_W-1:0];
                    cfg_d.lo_lim = cfg_wdata[2*CNT_W-1:CNT_W];
                end
                A_THR: begin
                    cfg_d.thr0 = cfg_wdata[CNT_W-1:0];
                    cfg_d.thr1 = cfg_wdata[2*CNT_W-1:CNT_W];
                end
                A_CTRL: begin
                    cfg_d.pause   = cfg_wdata[0];
                    cfg_d.clr     = cfg_wdata[1];
                    cfg_d.ev_en   = cfg_wdata[CTRL_EV_LSB +: NEV];
                    cfg_d.flt_en  = cfg_wdata[CTRL_FEN];
                    cfg_d.flt_thr = cfg_wdata[CTRL_FTHR_LSB +: FLT_W];
                end
                A_IRQ: begin
                    cfg_d.irq_en = cfg_wdata[0];
                    irq_clr_o    = cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.hi_lim <= {1'b0, {(CNT_W-1){1'b1}}};
            cfg_q.lo_lim <= {1'b1, {(CNT_W-1){1'b0}}};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // a clear bit written high reaches the register on the next edge
    p_clr_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_CTRL && cfg_wdata[1]) |=> cfg_q.clr);
endmodule

// File: rtl/pcnt_infilt.sv
module pcnt_infilt #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic          en_i,
    input  logic [FW-1:0] thr_i,
    output logic          filt_o
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [FW-1:0] cnt;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic [FW:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        cnt_inc = {1'b0, st_q.cnt} + {{FW{1'b0}}, 1'b1};
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (!en_i || cnt_inc >= {1'b0, thr_i}) begin
            st_d.filt = st_q.s2;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = cnt_inc[FW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;

    // a fresh level change is never accepted on its first cycle when T >= 2
    p_glitch_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && thr_i > FW'(1) && st_q.s2 != st_q.filt && st_q.cnt == '0)
        |=> st_q.filt == $past(st_q.filt));
endmodule

// File: rtl/pcnt_chan.sv
module pcnt_chan
    import pcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic              ctrl_i,
    input  chan_cfg_t         ccfg_i,
    output logic signed [1:0] step_o
);
    typedef struct packed {
        logic prev;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic rise, fall;
    edge_act_e eact;
    lvl_act_e lact;
    logic signed [1:0] base;

    always_comb begin
        st_d.prev = pulse_i;
        rise = pulse_i & ~st_q.prev;
        fall = ~pulse_i & st_q.prev;
        if (rise)      eact = edge_act_e'(ccfg_i.rise_act);
        else if (fall) eact = edge_act_e'(ccfg_i.fall_act);
        else           eact = E_HOLD;
        case (eact)
            E_INC:   base = 2'sd1;
            E_DEC:   base = -2'sd1;
            default: base = 2'sd0;
        endcase
        lact = lvl_act_e'(ctrl_i ? ccfg_i.hi_act : ccfg_i.lo_act);
        case (lact)
            L_KEEP:  step_o = base;
            L_INV:   step_o = -base;
            default: step_o = 2'sd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a pulse level that has not moved since the last edge asks for nothing
    p_idle_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i == $past(pulse_i)) |-> (step_o == 2'sd0));
endmodule

// File: rtl/pcnt_unit.sv
module pcnt_unit
    import pcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    sig_in,
    input  logic [NCH-1:0]    ctl_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq_o
);
    localparam int XW  = CNT_W + 2;
    localparam int MSB = CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        zc_mode_e         zc;
        logic [NEV-1:0]   flags;
        logic             irq_st;
    } core_t;

    unit_cfg_t cfg;
    logic irq_clr;
    logic [NIN-1:0] raw_in, filt;
    logic [NCH-1:0][1:0] step_w;

    core_t core_d, core_q;
    logic signed [XW-1:0] sum, nxt, cur_x, hi_x, lo_x, t0_x, t1_x;
    logic [NEV-1:0] ev_raw, ev_hit;

    pcnt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg),
        .irq_clr_o (irq_clr)
    );

    assign raw_in = {ctl_in, sig_in};

    for (genvar i = 0; i < NIN; i++) begin : g_in
        pcnt_infilt #(.FW(FLT_W)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_in[i]),
            .en_i   (cfg.flt_en),
            .thr_i  (cfg.flt_thr),
            .filt_o (filt[i])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pcnt_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (filt[c]),
            .ctrl_i  (filt[NCH+c]),
            .ccfg_i  (cfg.ch[c]),
            .step_o  (step_w[c])
        );
    end

    always_comb begin
        sum = '0;
        for (int c = 0; c < NCH; c++) begin
            sum = sum + $signed({{CNT_W{step_w[c][1]}}, step_w[c]});
        end
        cur_x = $signed({{2{core_q.count[MSB]}}, core_q.count});
        hi_x  = $signed({{2{cfg.hi_lim[MSB]}}, cfg.hi_lim});
        lo_x  = $signed({{2{cfg.lo_lim[MSB]}}, cfg.lo_lim});
        t0_x  = $signed({{2{cfg.thr0[MSB]}}, cfg.thr0});
        t1_x  = $signed({{2{cfg.thr1[MSB]}}, cfg.thr1});
        nxt   = cur_x + sum;
    end

    always_comb begin
        core_d = core_q;
        ev_raw = '0;
        if (cfg.clr) begin
            core_d.count = '0;
        end else if (!cfg.pause && sum != '0) begin
            if (nxt >= hi_x) begin
                ev_raw[EV_HIGH] = 1'b1;
                core_d.count    = '0;
            end else if (nxt <= lo_x) begin
                ev_raw[EV_LOW] = 1'b1;
                core_d.count   = '0;
            end else begin
                core_d.count = nxt[CNT_W-1:0];
                if (nxt == t0_x) ev_raw[EV_THR0] = 1'b1;
                if (nxt == t1_x) ev_raw[EV_THR1] = 1'b1;
                if (cur_x > 0 && nxt <= 0) begin
                    ev_raw[EV_ZERO] = 1'b1;
                    core_d.zc       = ZC_POS_ZERO;
                end else if (cur_x < 0 && nxt >= 0) begin
                    ev_raw[EV_ZERO] = 1'b1;
                    core_d.zc       = ZC_NEG_ZERO;
                end else if (cur_x == 0 && nxt < 0) begin
                    ev_raw[EV_ZERO] = 1'b1;
                    core_d.zc       = ZC_ZERO_NEG;
                end else if (cur_x == 0 && nxt > 0) begin
                    ev_raw[EV_ZERO] = 1'b1;
                    core_d.zc       = ZC_ZERO_POS;
                end
            end
        end
        ev_hit        = ev_raw & cfg.ev_en;
        core_d.flags  = (irq_clr ? '0 : core_q.flags) | ev_hit;
        core_d.irq_st = (core_q.irq_st & ~irq_clr) | (|ev_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign irq_o = core_q.irq_st & cfg.irq_en;

    always_comb begin
        cfg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cfg_addr == ADDR_W'(c)) cfg_rdata = DATA_W'(cfg.ch[c]);
        end
        case (cfg_addr)
            A_LIM:  cfg_rdata = DATA_W'({cfg.lo_lim, cfg.hi_lim});
            A_THR:  cfg_rdata = DATA_W'({cfg.thr1, cfg.thr0});
            A_CTRL: cfg_rdata = DATA_W'({cfg.flt_thr, cfg.flt_en, cfg.ev_en, cfg.clr, cfg.pause});
            A_IRQ:  cfg_rdata = DATA_W'({core_q.irq_st, cfg.irq_en});
            A_CNT:  cfg_rdata = {{(DATA_W-CNT_W){core_q.count[MSB]}}, core_q.count};
            A_STAT: cfg_rdata = DATA_W'({core_q.flags, core_q.zc});
            default: ;
        endcase
    end

    p_pause_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pause && !cfg.clr) |=> core_q.count == $past(core_q.count));

    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.clr |=> core_q.count == '0);

    p_limit_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_raw[EV_HIGH] || ev_raw[EV_LOW]) |=> core_q.count == '0);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_hit) |=> core_q.irq_st);
endmodule

// File: tb/pcnt_unit_bench.sv
`timescale 1ns/1ps
module pcnt_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sig_in = '0;
    logic [1:0] ctl_in = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic irq_o;
    int n_chk = 0;
    int n_err = 0;
    logic [31:0] ctl = '0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    pcnt_unit u_pcnt_unit (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ctl_in(ctl_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] r);
        @(negedge clk); cfg_addr = a; #0.5; r = cfg_rdata;
    endtask

    task automatic pulse(input int c, input int w);
        @(negedge clk); sig_in[c] = 1'b1;
        repeat (w) @(negedge clk);
        sig_in[c] = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_both(input int w);
        @(negedge clk); sig_in = 2'b11;
        repeat (w) @(negedge clk);
        sig_in = 2'b00;
        repeat (8) @(negedge clk);
    endtask

    task automatic zero_cnt();
        wr(3'd4, ctl | 32'h2);
        wr(3'd4, ctl);
    endtask

    task automatic irq_clear();
        wr(3'd5, 32'h3);
    endtask

    function automatic int act(input int e, input int l);
        int b;
        b = (e == 1) ? 1 : (e == 2) ? -1 : 0;
        if (l == 0) return b;
        if (l == 1) return -b;
        return 0;
    endfunction

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd6, v); chk("R1 count", v, 32'h0);
        rd(3'd7, v); chk("R1 status", v, 32'h0);
        rd(3'd5, v); chk("R1 irq reg", v, 32'h0);
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        rd(3'd2, v); chk("R1 limits", v, 32'h8000_7FFF);

        // R2 R3 sweep of edge and level actions on each channel
        for (int c = 0; c < 2; c++) begin
            wr(3'(1 - c), 32'h0);
            for (int lv = 0; lv < 2; lv++) begin
                ctl_in[c] = lv[0];
                repeat (6) @(negedge clk);
                for (int ra = 0; ra < 4; ra++) begin
                    for (int fa = 0; fa < 4; fa++) begin
                        for (int la = 0; la < 4; la++) begin
                            logic [1:0] oth;
                            logic [7:0] w;
                            oth = (la == 1) ? 2'd0 : 2'd1;
                            w = (lv == 1) ? {oth, la[1:0], fa[1:0], ra[1:0]}
                                          : {la[1:0], oth, fa[1:0], ra[1:0]};
                            wr(3'(c), {24'b0, w});
                            zero_cnt();
                            pulse(c, 3);
                            rd(3'd6, v);
                            chk("R2/R3 sweep", v, 32'(act(ra, la) + act(fa, la)));
                        end
                    end
                end
            end
            ctl_in[c] = 1'b0;
            wr(3'(c), 32'h0);
        end
        repeat (6) @(negedge clk);

        // R13 latency: ch0 rise = add one
        wr(3'd0, 32'h01);
        zero_cnt();
        cfg_addr = 3'd6;
        @(negedge clk); sig_in[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R13 before 4th edge", cfg_rdata, 32'h0);
        @(negedge clk); chk("R13 on 4th edge", cfg_rdata, 32'h1);
        sig_in[0] = 1'b0;
        repeat (8) @(negedge clk);

        // R4 both channels in the same cycle
        wr(3'd1, 32'h01);
        zero_cnt();
        pulse_both(3);
        rd(3'd6, v); chk("R4 inc+inc", v, 32'h2);
        wr(3'd1, 32'h02);
        pulse_both(3);
        rd(3'd6, v); chk("R4 inc+dec", v, 32'h2);

        // R5 sign extension (ch1 subtracts)
        zero_cnt();
        for (int k = 0; k < 3; k++) pulse(1, 3);
        rd(3'd6, v); chk("R5 negative read", v, 32'hFFFF_FFFD);

        // R6 limits: high 3, low -2, events enabled, irq enabled
        ctl = 32'h0000_007C;
        wr(3'd4, ctl);
        wr(3'd2, {16'hFFFE, 16'h0003});
        wr(3'd5, 32'h1);
        zero_cnt(); irq_clear();
        pulse(0, 3); pulse(0, 3);
        rd(3'd6, v); chk("R6 below high", v, 32'h2);
        irq_clear();
        pulse(0, 3);
        rd(3'd6, v); chk("R6 high wrap", v, 32'h0);
        rd(3'd7, v); chk("R6 high flag", {25'b0, v[6:2]}, 32'h08);
        chk("R9 irq after event", {31'b0, irq_o}, 32'h1);
        irq_clear();
        chk("R9 irq cleared", {31'b0, irq_o}, 32'h0);
        rd(3'd7, v); chk("R9 flags cleared", {25'b0, v[6:2]}, 32'h0);
        pulse(1, 3);
        irq_clear();
        pulse(1, 3);
        rd(3'd6, v); chk("R6 low wrap", v, 32'h0);
        rd(3'd7, v); chk("R6 low flag", {25'b0, v[6:2]}, 32'h04);
        wr(3'd2, 32'h8000_7FFF);

        // R8 zero crossing directions
        zero_cnt(); irq_clear();
        pulse(0, 3);
        rd(3'd7, v); chk("R8 zero to pos", {30'b0, v[1:0]}, 32'd3);
        chk("R8 zero flag", {31'b0, v[6]}, 32'h1);
        pulse(1, 3);
        rd(3'd7, v); chk("R8 pos to zero", {30'b0, v[1:0]}, 32'd0);
        pulse(1, 3);
        rd(3'd7, v); chk("R8 zero to neg", {30'b0, v[1:0]}, 32'd2);
        pulse(0, 3);
        rd(3'd7, v); chk("R8 neg to zero", {30'b0, v[1:0]}, 32'd1);

        // R7 thresholds: thr0 = 2, thr1 = -1
        wr(3'd3, {16'hFFFF, 16'h0002});
        zero_cnt(); irq_clear();
        pulse(0, 3);
        rd(3'd7, v); chk("R7 no threshold at 1", {30'b0, v[3:2]}, 32'h0);
        pulse(0, 3);
        rd(3'd7, v); chk("R7 thr0 hit", {30'b0, v[3:2]}, 32'h2);
        zero_cnt(); irq_clear();
        pulse(1, 3);
        rd(3'd7, v); chk("R7 thr1 hit", {30'b0, v[3:2]}, 32'h1);

        // R9 event and clear in the same cycle: event must win
        zero_cnt(); irq_clear();
        pulse(0, 3);
        irq_clear();
        @(negedge clk); sig_in[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h3;
        @(negedge clk); cfg_we = 1'b0;
        chk("R9 set wins over clear", {31'b0, irq_o}, 32'h1);
        sig_in[0] = 1'b0;
        repeat (8) @(negedge clk);
        wr(3'd5, 32'h2);
        chk("R9 gated by enable", {31'b0, irq_o}, 32'h0);
        rd(3'd5, v); chk("R9 status bit", v, 32'h0);

        // R10 pause
        ctl = 32'h0;
        zero_cnt();
        pulse(0, 3);
        wr(3'd4, 32'h1);
        pulse(0, 3); pulse(0, 3);
        rd(3'd6, v); chk("R10 paused", v, 32'h1);
        wr(3'd4, 32'h0);
        pulse(0, 3);
        rd(3'd6, v); chk("R10 resumed", v, 32'h2);

        // R11 clear held
        wr(3'd4, 32'h2);
        rd(3'd6, v); chk("R11 cleared", v, 32'h0);
        pulse(0, 3);
        rd(3'd6, v); chk("R11 held at zero", v, 32'h0);
        wr(3'd4, 32'h0);
        pulse(0, 3);
        rd(3'd6, v); chk("R11 released", v, 32'h1);

        // R12 glitch filter with T = 5
        ctl = (32'd5 << 8) | 32'h80;
        wr(3'd4, ctl);
        zero_cnt();
        pulse(0, 4);
        rd(3'd6, v); chk("R12 short pulse ignored", v, 32'h0);
        pulse(0, 5);
        rd(3'd6, v); chk("R12 pulse of T passes", v, 32'h1);
        pulse(0, 1);
        rd(3'd6, v); chk("R12 glitch ignored", v, 32'h1);
        ctl = 32'h0;
        wr(3'd4, ctl);
        pulse(0, 1);
        rd(3'd6, v); chk("R12 filter off passes", v, 32'h2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule